// File: doc/BRIEF.md
# Delimited XOR-Checked Frame Receiver

This block sits behind a UART receiver and turns its stream of bytes into decoded frames. A frame opens with the start marker 0x32 and closes with the end marker 0x34. Between them come a source address, a destination address, a command code, the data bytes and a one-byte checksum. The frame does not carry its own length. A short frame is 7 bytes with one data byte, and a long frame is 14 bytes with eight. The receiver works out which kind it has by looking for the end marker at position 6 or position 13, each time with a valid checksum in the byte just before it.

Frames addressed to the local address, or to one of a small set of group addresses that can each be enabled, are presented for one cycle on registered outputs. Frames for other destinations are dropped silently. A frame that fails its checks, or that stalls for longer than a programmable number of idle cycles, is thrown away and reported with a one-cycle error pulse and a reason code. After that the receiver goes back to looking for a start marker.

Top module: `xframe_rx`

## Requirements
- R1: A frame laid out as 0x32, source, destination, command, data, checksum, 0x34 is delivered as a one-cycle `out_valid` pulse in the cycle after its last byte is taken. `out_src`, `out_dst` and `out_cmd` hold bytes 1, 2 and 3. Data byte k (counting from 0) appears at `out_data[8k+7:8k]`. For a 14-byte frame, `out_long` is 1.
- R2: The checksum is the XOR of every byte between the start marker and the checksum byte. A 14-byte frame whose checksum does not match is not delivered.
- R3: When byte 6 is 0x34 and the XOR of bytes 1 to 5 is zero, the frame ends there as a short frame. In that case `out_long` is 0, the single data byte is in `out_data[7:0]` and the upper bits are 0.
- R4: When byte 6 is 0x34 but the short checksum fails, the frame does not end. Reception continues to 14 bytes.
- R5: While waiting for a start marker, any other byte is ignored and causes neither a frame nor an error.
- R6: At byte 13, a value other than 0x34 raises `err_valid` for one cycle with code 2. If byte 13 is 0x34 but the checksum fails, the code is 1. In both cases no frame is delivered.
- R7: Once a frame is under way, `tmo_limit` consecutive cycles without `in_valid` abort it with error code 3. Fewer idle cycles have no effect, and idle time while waiting for a start marker raises no error.
- R8: After any error, the next well-formed frame is received normally.
- R9: A frame is delivered only if its destination equals `local_addr`, or equals group slot i (`grp_addr[8i+7:8i]`) while `grp_en[i]` is 1. A frame that passes its checks but is filtered out raises no error.
- R10: Reset drives `out_valid` and `err_valid` low and discards any partial frame.
- R11: `out_valid` and `err_valid` are never high in the same cycle, and `out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe from the UART |
| in_byte | input | W | Received byte |
| local_addr | input | W | Address of this node |
| grp_addr | input | GRP_N*W | Group destination slots |
| grp_en | input | GRP_N | Enable for each group slot |
| tmo_limit | input | TMO_W | Idle cycles that abort a partial frame (at least 1) |
| out_valid | output | 1 | Frame delivered |
| out_src | output | W | Source address |
| out_dst | output | W | Destination address |
| out_cmd | output | W | Command code |
| out_long | output | 1 | 1 for a 14-byte frame |
| out_data | output | 8*W | Data bytes, first byte lowest |
| err_valid | output | 1 | Frame discarded |
| err_code | output | 2 | 1 checksum, 2 end marker, 3 timeout |

## Verification
The bench builds the block with W=8, GRP_N=2 and TMO_W=8, and drives `tmo_limit` to 8. With a limit that small, both sides of the timeout edge can be reached: seven idle cycles and eight idle cycles. Two group slots let one run cover an enabled group, a disabled group, and a group enabled partway through the run. The table vectors put a 0x34 data byte at position 6 and also cover a corrupted checksum and a wrong end marker.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  localparam int unsigned SHORT_LEN = 7;
  localparam int unsigned LONG_LEN  = 14;
  localparam int unsigned SHORT_END = SHORT_LEN - 1;
  localparam int unsigned LONG_END  = LONG_LEN - 1;
  // bytes other than markers, header and checksum
  localparam int unsigned SHORT_DATA = SHORT_LEN - 6;
  localparam int unsigned LONG_DATA  = LONG_LEN - 6;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_SUM  = 2'd1,
    ERR_END  = 2'd2,
    ERR_TMO  = 2'd3
  } err_e;

  typedef enum logic {
    ST_HUNT,
    ST_BODY
  } st_e;
endpackage

// File: rtl/xfr_xsum.sv
module xfr_xsum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic         zero
);
  logic [W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc ^ din;
  end

  assign zero = (acc == '0);
endmodule

// File: rtl/xfr_gap.sv
module xfr_gap #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          kick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || kick) cnt <= '0;
    else                     cnt <= cnt + TW'(1);
  end

  assign expire = run && !kick && (cnt == limit - TW'(1));
endmodule

// File: rtl/xfr_store.sv
module xfr_store #(
  parameter int W     = 8,
  parameter int SLOTS = 12,
  parameter int IW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [W-1:0]       din,
  output logic [SLOTS*W-1:0] flat
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                          r <= '0;
      else if (we && idx == IW'(g))     r <= din;
    end
    assign flat[g*W +: W] = r;
  end
endmodule

// File: rtl/xfr_match.sv
module xfr_match #(
  parameter int W     = 8,
  parameter int GRP_N = 2
) (
  input  logic [W-1:0]       dst,
  input  logic [W-1:0]       local_addr,
  input  logic [GRP_N*W-1:0] grp_addr,
  input  logic [GRP_N-1:0]   grp_en,
  output logic               hit
);
  logic [GRP_N-1:0] grp_hit;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign grp_hit[g] = grp_en[g] && (dst == grp_addr[g*W +: W]);
  end

  assign hit = (dst == local_addr) || (|grp_hit);
endmodule

// File: rtl/xframe_rx.sv
module xframe_rx #(
  parameter int         W        = 8,
  parameter int         GRP_N    = 2,
  parameter int         TMO_W    = 16,
  parameter logic [7:0] SOF_BYTE = 8'h32,
  parameter logic [7:0] EOF_BYTE = 8'h34
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  input  logic [W-1:0]                        in_byte,
  input  logic [W-1:0]                        local_addr,
  input  logic [GRP_N*W-1:0]                  grp_addr,
  input  logic [GRP_N-1:0]                    grp_en,
  input  logic [TMO_W-1:0]                    tmo_limit,
  output logic                                out_valid,
  output logic [W-1:0]                        out_src,
  output logic [W-1:0]                        out_dst,
  output logic [W-1:0]                        out_cmd,
  output logic                                out_long,
  output logic [xfr_pkg::LONG_DATA*W-1:0]     out_data,
  output logic                                err_valid,
  output logic [1:0]                          err_code
);
  import xfr_pkg::*;

  localparam int SLOTS  = LONG_LEN - 2;
  localparam int PW     = $clog2(LONG_LEN);
  localparam int DATA_W = LONG_DATA * W;
  localparam int D0     = 3;  // slot of first data byte

  st_e              st;
  logic [PW-1:0]    pos;
  logic             take, at_short, at_long, short_ok, sum_zero, hit, expire, wr;
  logic [SLOTS*W-1:0] flat;
  logic [PW-1:0]    idx;
  logic [W-1:0]     f_src, f_dst, f_cmd;
  logic [DATA_W-1:0] d_short, d_long;

  always_comb begin
    take     = (st == ST_BODY) && in_valid;
    at_short = take && (pos == PW'(SHORT_END));
    at_long  = take && (pos == PW'(LONG_END));
    short_ok = at_short && (in_byte == W'(EOF_BYTE)) && sum_zero;
    wr       = take && !at_long;
    idx      = pos - PW'(1);
    f_src    = flat[0 +: W];
    f_dst    = flat[W +: W];
    f_cmd    = flat[2*W +: W];
    d_short  = {{(DATA_W-SHORT_DATA*W){1'b0}}, flat[D0*W +: SHORT_DATA*W]};
    d_long   = flat[D0*W +: DATA_W];
  end

  xfr_xsum #(.W(W)) u_sum (
    .clk(clk), .rst(rst), .clr(st == ST_HUNT), .en(wr), .din(in_byte), .zero(sum_zero)
  );

  xfr_gap #(.TW(TMO_W)) u_gap (
    .clk(clk), .rst(rst), .run(st == ST_BODY), .kick(in_valid),
    .limit(tmo_limit), .expire(expire)
  );

  xfr_store #(.W(W), .SLOTS(SLOTS), .IW(PW)) u_store (
    .clk(clk), .rst(rst), .we(wr), .idx(idx), .din(in_byte), .flat(flat)
  );

  xfr_match #(.W(W), .GRP_N(GRP_N)) u_match (
    .dst(f_dst), .local_addr(local_addr), .grp_addr(grp_addr),
    .grp_en(grp_en), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HUNT;
      pos       <= '0;
      out_valid <= 1'b0;
      out_src   <= '0;
      out_dst   <= '0;
      out_cmd   <= '0;
      out_long  <= 1'b0;
      out_data  <= '0;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      out_valid <= 1'b0;
      err_valid <= 1'b0;
      unique case (st)
        ST_HUNT: begin
          if (in_valid && in_byte == W'(SOF_BYTE)) begin
            st  <= ST_BODY;
            pos <= PW'(1);
          end
        end
        ST_BODY: begin
          if (expire) begin
            st        <= ST_HUNT;
            err_valid <= 1'b1;
            err_code  <= ERR_TMO;
          end else if (short_ok) begin
            st <= ST_HUNT;
            if (hit) begin
              out_valid <= 1'b1;
              out_src   <= f_src;
              out_dst   <= f_dst;
              out_cmd   <= f_cmd;
              out_long  <= 1'b0;
              out_data  <= d_short;
            end
          end else if (at_long) begin
            st <= ST_HUNT;
            if (in_byte != W'(EOF_BYTE)) begin
              err_valid <= 1'b1;
              err_code  <= ERR_END;
            end else if (!sum_zero) begin
              err_valid <= 1'b1;
              err_code  <= ERR_SUM;
            end else if (hit) begin
              out_valid <= 1'b1;
              out_src   <= f_src;
              out_dst   <= f_dst;
              out_cmd   <= f_cmd;
              out_long  <= 1'b1;
              out_data  <= d_long;
            end
          end else if (take) begin
            pos <= pos + PW'(1);
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/xfr_rx_chk.sv
module xfr_rx_chk #(
  parameter int         W        = 8,
  parameter int         GRP_N    = 2,
  parameter logic [7:0] EOF_BYTE = 8'h34
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [W-1:0]       in_byte,
  input logic [W-1:0]       local_addr,
  input logic [GRP_N*W-1:0] grp_addr,
  input logic [GRP_N-1:0]   grp_en,
  input logic               out_valid,
  input logic [W-1:0]       out_dst,
  input logic               err_valid,
  input logic [1:0]         err_code
);
  logic dst_ok;
  always_comb begin
    dst_ok = (out_dst == local_addr);
    for (int i = 0; i < GRP_N; i++)
      if (grp_en[i] && out_dst == grp_addr[i*W +: W]) dst_ok = 1'b1;
  end

  // R11
  excl_out_err_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !err_valid);
  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R6
  err_code_set_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code != 2'd0));
  // R7
  tmo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code == 2'd3) |-> !$past(in_valid));
  // R6
  byte_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code != 2'd3) |-> $past(in_valid));
  // R1
  end_on_marker_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && $past(in_byte) == W'(EOF_BYTE)));
  // R9
  dest_ok_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> dst_ok);
endmodule

bind xframe_rx xfr_rx_chk #(.W(W), .GRP_N(GRP_N), .EOF_BYTE(EOF_BYTE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
  .local_addr(local_addr), .grp_addr(grp_addr), .grp_en(grp_en),
  .out_valid(out_valid), .out_dst(out_dst), .err_valid(err_valid),
  .err_code(err_code)
);

// File: tb/test_xframe_rx.sv
module test_xframe_rx;
  localparam int W = 8, GRP_N = 2, TMO_W = 8;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [W-1:0] in_byte = '0, local_addr = 8'h20;
  logic [GRP_N*W-1:0] grp_addr = {8'hAD, 8'hEB};
  logic [GRP_N-1:0] grp_en = 2'b01;
  logic [TMO_W-1:0] tmo_limit = 8'd8;
  logic out_valid, out_long, err_valid;
  logic [W-1:0] out_src, out_dst, out_cmd;
  logic [8*W-1:0] out_data;
  logic [1:0] err_code;

  always #2 clk = ~clk;

  xframe_rx #(.W(W), .GRP_N(GRP_N), .TMO_W(TMO_W)) i_xframe_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .local_addr(local_addr), .grp_addr(grp_addr), .grp_en(grp_en),
    .tmo_limit(tmo_limit), .out_valid(out_valid), .out_src(out_src),
    .out_dst(out_dst), .out_cmd(out_cmd), .out_long(out_long),
    .out_data(out_data), .err_valid(err_valid), .err_code(err_code)
  );

  // captured at the ports
  int fr_cnt = 0, er_cnt = 0;
  logic [W-1:0] c_src, c_dst, c_cmd;
  logic [8*W-1:0] c_data;
  logic c_long;
  logic [1:0] c_code;
  always @(negedge clk) begin
    if (out_valid) begin
      fr_cnt <= fr_cnt + 1;
      c_src <= out_src; c_dst <= out_dst; c_cmd <= out_cmd;
      c_data <= out_data; c_long <= out_long;
    end
    if (err_valid) begin
      er_cnt <= er_cnt + 1;
      c_code <= err_code;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [111:0] b;
    logic [3:0]   n;
    logic [1:0]   kind;  // 0 dropped, 1 delivered, 2 error
    logic [1:0]   code;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R1 R2 long to local
    '{112'h32842052_0000000000000000_F634, 4'd14, 2'd1, 2'd0},
    // R9 destination 84 not ours
    '{112'h32208452_494A4BFD8100004A_8834, 4'd14, 2'd0, 2'd0},
    // R3 R9 short to enabled group EB
    '{{56'h3284EBF9009634, 56'h0}, 4'd7, 2'd1, 2'd0},
    // R3 short to local
    '{{56'h328420FD005934, 56'h0}, 4'd7, 2'd1, 2'd0},
    // R6 R2 bad checksum
    '{112'h32842053_0000000000000000_0034, 4'd14, 2'd2, 2'd1},
    // R6 wrong end marker
    '{112'h32842053_0000000000000000_F735, 4'd14, 2'd2, 2'd2},
    // R4 0x34 at byte 6, short sum fails
    '{112'h32842011_2233340000000000_9034, 4'd14, 2'd1, 2'd0},
    // R9 group AD disabled
    '{{56'h3284ADD101F934, 56'h0}, 4'd7, 2'd0, 2'd0}
  };

  task automatic send_vec(input int v);
    for (int i = 0; i < int'(VEC[v].n); i++) put(VEC[v].b[111 - 8*i -: 8]);
  endtask

  function automatic logic [7:0] vb(input int v, input int i);
    return VEC[v].b[111 - 8*i -: 8];
  endfunction

  task automatic check_frame(input int v, input int f0, input int e0, input string tag);
    logic [63:0] ed;
    bit lg;
    lg = (VEC[v].n == 4'd14);
    ed = '0;
    if (lg) for (int k = 0; k < 8; k++) ed[8*k +: 8] = vb(v, 4 + k);
    else ed[7:0] = vb(v, 4);
    chk(fr_cnt == f0 + 1 && er_cnt == e0, {tag, " frame count"}, fr_cnt - f0, 1);
    chk(c_src == vb(v, 1), {tag, " src"}, c_src, vb(v, 1));
    chk(c_dst == vb(v, 2), {tag, " dst"}, c_dst, vb(v, 2));
    chk(c_cmd == vb(v, 3), {tag, " cmd"}, c_cmd, vb(v, 3));
    chk(c_long == lg, {tag, " long flag"}, c_long, lg);
    chk(c_data == ed, {tag, " data"}, c_data, ed);
  endtask

  initial begin
    int f0, e0;
    idle(3);
    // R10 reset state
    chk(!out_valid && !err_valid, "R10 reset outputs", {out_valid, err_valid}, 0);
    rst = 1'b0;
    idle(2);

    for (int v = 0; v < NV; v++) begin
      f0 = fr_cnt; e0 = er_cnt;
      send_vec(v);
      idle(3);
      case (VEC[v].kind)
        2'd1: check_frame(v, f0, e0, $sformatf("R1 vector %0d", v));
        2'd0: chk(fr_cnt == f0 && er_cnt == e0, $sformatf("R9 vector %0d dropped", v),
                  fr_cnt - f0 + er_cnt - e0, 0);
        default: begin
          chk(er_cnt == e0 + 1 && fr_cnt == f0, $sformatf("R6 vector %0d error pulse", v),
              er_cnt - e0, 1);
          chk(c_code == VEC[v].code, $sformatf("R6 vector %0d code", v), c_code, VEC[v].code);
        end
      endcase
    end

    // R5 junk before start marker
    f0 = fr_cnt; e0 = er_cnt;
    put(8'hAA); put(8'h34); put(8'h55); idle(2);
    send_vec(3); idle(3);
    check_frame(3, f0, e0, "R5 resync");

    // R7 long idle while hunting
    e0 = er_cnt; idle(40);
    chk(er_cnt == e0, "R7 hunt idle", er_cnt - e0, 0);

    // R7 gap of limit-1 tolerated
    f0 = fr_cnt; e0 = er_cnt;
    put(8'h32); put(8'h84); put(8'h20); idle(7);
    put(8'hFD); put(8'h00); put(8'h59); put(8'h34); idle(3);
    check_frame(3, f0, e0, "R7 short gap");

    // R7 gap of limit aborts, R8 recovery
    f0 = fr_cnt; e0 = er_cnt;
    put(8'h32); put(8'h84); idle(10);
    chk(er_cnt == e0 + 1 && c_code == 2'd3, "R7 timeout code", c_code, 3);
    send_vec(0); idle(3);
    check_frame(0, f0, e0 + 1, "R8 after timeout");

    // R8 recovery after end-marker error
    f0 = fr_cnt; e0 = er_cnt;
    send_vec(5); idle(2); send_vec(2); idle(3);
    check_frame(2, f0, e0 + 1, "R8 after end error");

    // R9 enabling group slot 1, disabling slot 0
    grp_en = 2'b10;
    f0 = fr_cnt; e0 = er_cnt;
    send_vec(7); idle(3);
    check_frame(7, f0, e0, "R9 group enabled");
    f0 = fr_cnt;
    send_vec(2); idle(3);
    chk(fr_cnt == f0, "R9 group disabled", fr_cnt - f0, 0);
    grp_en = 2'b01;

    // R10 reset discards a partial frame
    f0 = fr_cnt; e0 = er_cnt;
    put(8'h32); put(8'h84); put(8'h20);
    rst = 1'b1; idle(2); rst = 1'b0;
    put(8'hFD); put(8'h00); put(8'h59); put(8'h34); idle(3);
    chk(fr_cnt == f0 && er_cnt == e0, "R10 partial frame dropped", fr_cnt - f0, 0);

    // R11 back-to-back short frames give separate pulses
    f0 = fr_cnt;
    send_vec(3); send_vec(3); idle(3);
    chk(fr_cnt == f0 + 2, "R11 two pulses", fr_cnt - f0, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
      $finish;
    end
  end
endmodule